// File: doc/BRIEF.md
# Compare Output Mode Generator

This block drives one output bit of a timer compare channel. Each cycle it sees two equality strobes from the surrounding timer. One says the count has reached this channel's compare value. The other says the count has reached the period value. A 3-bit mode selects what each event does to the bit: set it, clear it, toggle it, or leave it alone. In mode 0 the bit simply tracks a software-written level.

The generator also knows whether the timer counts up only (or free-runs) or counts up and down. In up/down counting it takes the count direction into account, so a single channel can produce edge-aligned PWM, center-aligned PWM or a square wave. The counter, the comparators and any dead-band logic are outside this block.

Top module: `cmp_out_gen`

## Requirements
- R1: While `rstN` is low and after its release, `outLvl` is 0 until the first enabled update.
- R2: With `outMode` = 3'b000 and `tmrEn` = 1, `outLvl` takes the value `swOut` had at the previous clock edge, on every such cycle, whatever the strobes are.
- R3: With `tmrEn` = 0, `outLvl` holds its value whatever the mode, strobes or `swOut` are.
- R4: With `upDownMode` = 0, a channel match (`chanMatch` = 1, `periodMatch` = 0) sets `outLvl` in modes 3'b001 and 3'b011, toggles it in modes 3'b010, 3'b100 and 3'b110, and clears it in modes 3'b101 and 3'b111.
- R5: With `upDownMode` = 0, a period match (`periodMatch` = 1, `chanMatch` = 0) clears `outLvl` in modes 3'b010 and 3'b011, sets it in modes 3'b110 and 3'b111, and has no effect in modes 3'b001, 3'b100 and 3'b101.
- R6: When both strobes are 1 in the same cycle and the mode gives the period match an action (modes 3'b010, 3'b011, 3'b110, 3'b111), only the period action is applied. In the other nonzero modes the channel action is applied.
- R7: With `upDownMode` = 1, a channel match toggles `outLvl` in modes 3'b010, 3'b100 and 3'b110, sets it in mode 3'b001 and clears it in mode 3'b101, whatever `countDown` is.
- R8: With `upDownMode` = 1, a channel match sets `outLvl` in mode 3'b011 and clears it in mode 3'b111 only while `countDown` = 0. With `countDown` = 1 it has no effect in those modes.
- R9: With `upDownMode` = 1, a period match clears `outLvl` in modes 3'b010 and 3'b011, sets it in modes 3'b110 and 3'b111, and does nothing in the other nonzero modes.
- R10: In a nonzero mode with `tmrEn` = 1 and both strobes 0, `outLvl` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tmrEn | input | 1 | Timer enable; the output updates only when this is 1 |
| upDownMode | input | 1 | 1 = the counter runs up/down, 0 = it runs up only or free-runs |
| countDown | input | 1 | 1 while the counter is decreasing (used only in up/down counting) |
| chanMatch | input | 1 | Count equals this channel's compare value |
| periodMatch | input | 1 | Count equals the period value |
| outMode | input | 3 | Output mode encoding, 3'b000 to 3'b111 |
| swOut | input | 1 | Software level used in mode 3'b000 |
| outLvl | output | 1 | Registered output level |

## Verification
Isolated single strobes in every mode show that each mode gives the channel event and the period event their own distinct actions. Cycles with both strobes at once show which event wins. A bench-driven up counter with period 8 and compare 5 in set/reset mode produces edge-aligned PWM. An up/down counter with period 7 and compare 4 in toggle/reset mode produces a center-aligned pulse. Forcing a channel match while the count falls in modes 3'b011 and 3'b111 shows the direction gating, and the disabled and idle patterns show the output holds.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TOG  = 2'd3
  } act_e;

  // Mode codes used by the decoder
  localparam logic [MODE_W-1:0] MODE_SW     = 3'b000;
  localparam logic [MODE_W-1:0] MODE_SET    = 3'b001;
  localparam logic [MODE_W-1:0] MODE_TOGCLR = 3'b010;
  localparam logic [MODE_W-1:0] MODE_SETCLR = 3'b011;
  localparam logic [MODE_W-1:0] MODE_TOG    = 3'b100;
  localparam logic [MODE_W-1:0] MODE_CLR    = 3'b101;
  localparam logic [MODE_W-1:0] MODE_TOGSET = 3'b110;
  localparam logic [MODE_W-1:0] MODE_CLRSET = 3'b111;

  // Strobes from control to datapath; at most one is high
  typedef struct packed {
    logic loadSw;
    logic setReq;
    logic clrReq;
    logic togReq;
  } strobes_t;

endpackage

// File: rtl/cmp_out_ctrl.sv
module cmp_out_ctrl
  import cmp_out_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tmrEn,
  input  logic              upDownMode,
  input  logic              countDown,
  input  logic              chanMatch,
  input  logic              periodMatch,
  input  logic [MODE_W-1:0] outMode,
  output strobes_t          strobes
);

  act_e chanAct;
  act_e perAct;
  act_e chosenAct;
  logic risingOnly;

  // Channel-match action per mode
  always_comb begin
    unique case (outMode)
      MODE_SET, MODE_SETCLR:             chanAct = ACT_SET;
      MODE_TOGCLR, MODE_TOG, MODE_TOGSET: chanAct = ACT_TOG;
      MODE_CLR, MODE_CLRSET:             chanAct = ACT_CLR;
      default:                           chanAct = ACT_NONE;
    endcase
  end

  // Set/reset and reset/set act on the channel match only while rising in up/down counting
  assign risingOnly = (outMode == MODE_SETCLR) || (outMode == MODE_CLRSET);

  // Period-match action per mode
  always_comb begin
    unique case (outMode)
      MODE_TOGCLR, MODE_SETCLR: perAct = ACT_CLR;
      MODE_TOGSET, MODE_CLRSET: perAct = ACT_SET;
      default:                  perAct = ACT_NONE;
    endcase
  end

  // Period match with an action wins over the channel match
  always_comb begin
    chosenAct = ACT_NONE;
    if (periodMatch && (perAct != ACT_NONE)) begin
      chosenAct = perAct;
    end else if (chanMatch) begin
      if (upDownMode && countDown && risingOnly) chosenAct = ACT_NONE;
      else                                      chosenAct = chanAct;
    end
  end

  always_comb begin
    strobes = '0;
    if (tmrEn) begin
      if (outMode == MODE_SW) begin
        strobes.loadSw = 1'b1;
      end else begin
        strobes.setReq = (chosenAct == ACT_SET);
        strobes.clrReq = (chosenAct == ACT_CLR);
        strobes.togReq = (chosenAct == ACT_TOG);
      end
    end
  end

  // Assertions
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes)) else $error("more than one strobe"); // R6
  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !tmrEn |-> (strobes == '0)) else $error("strobe while disabled"); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (tmrEn && outMode != MODE_SW && !chanMatch && !periodMatch) |-> (strobes == '0))
    else $error("strobe without event"); // R10
  AST_FALL_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (upDownMode && countDown && !periodMatch && risingOnly) |-> (strobes == '0))
    else $error("falling match acted"); // R8

endmodule

// File: rtl/cmp_out_dp.sv
module cmp_out_dp
  import cmp_out_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     swOut,
  input  strobes_t strobes,
  output logic     outLvl
);

  logic nextLvl;

  always_comb begin
    nextLvl = outLvl;
    if (strobes.loadSw)      nextLvl = swOut;
    else if (strobes.setReq) nextLvl = 1'b1;
    else if (strobes.clrReq) nextLvl = 1'b0;
    else if (strobes.togReq) nextLvl = ~outLvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outLvl <= 1'b0;
    else       outLvl <= nextLvl;
  end

  // Assertions
  AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setReq |=> outLvl) else $error("set missed"); // R4
  AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrReq |=> !outLvl) else $error("clear missed"); // R5
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.togReq |=> (outLvl != $past(outLvl))) else $error("toggle missed"); // R7
  AST_SW_COPY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadSw |=> (outLvl == $past(swOut))) else $error("sw copy missed"); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> $stable(outLvl)) else $error("output moved"); // R3

endmodule

// File: rtl/cmp_out_gen.sv
module cmp_out_gen
  import cmp_out_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tmrEn,
  input  logic              upDownMode,
  input  logic              countDown,
  input  logic              chanMatch,
  input  logic              periodMatch,
  input  logic [MODE_W-1:0] outMode,
  input  logic              swOut,
  output logic              outLvl
);

  strobes_t strobes;

  cmp_out_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .tmrEn       (tmrEn),
    .upDownMode  (upDownMode),
    .countDown   (countDown),
    .chanMatch   (chanMatch),
    .periodMatch (periodMatch),
    .outMode     (outMode),
    .strobes     (strobes)
  );

  cmp_out_dp uDp (
    .clk     (clk),
    .rstN    (rstN),
    .swOut   (swOut),
    .strobes (strobes),
    .outLvl  (outLvl)
  );

endmodule

// File: tb/tb_cmp_out_gen.sv
module tb_cmp_out_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tmrEn = 1'b0;
  logic       upDownMode = 1'b0;
  logic       countDown = 1'b0;
  logic       chanMatch = 1'b0;
  logic       periodMatch = 1'b0;
  logic [2:0] outMode = 3'b000;
  logic       swOut = 1'b0;
  logic       outLvl;

  int checks = 0;
  int errors = 0;
  bit model = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmp_out_gen dut (
    .clk(clk), .rstN(rstN), .tmrEn(tmrEn), .upDownMode(upDownMode),
    .countDown(countDown), .chanMatch(chanMatch), .periodMatch(periodMatch),
    .outMode(outMode), .swOut(swOut), .outLvl(outLvl)
  );

  // Behavioural reference: 0 none, 1 set, 2 clear, 3 toggle
  function automatic bit refNext(bit cur, bit en, bit ud, bit dn, bit cm, bit pm,
                                 int md, bit sw);
    int pa;
    int ca;
    int act;
    if (!en) return cur;
    if (md == 0) return sw;
    pa = (md == 2 || md == 3) ? 2 : ((md == 6 || md == 7) ? 1 : 0);
    if (md == 1 || md == 3) ca = 1;
    else if (md == 5 || md == 7) ca = 2;
    else ca = 3;
    if (ud && dn && (md == 3 || md == 7)) ca = 0;
    act = 0;
    if (pm && pa != 0) act = pa;
    else if (cm) act = ca;
    case (act)
      1: return 1'b1;
      2: return 1'b0;
      3: return !cur;
      default: return cur;
    endcase
  endfunction

  task automatic check(string tag);
    checks++;
    if (outLvl !== model) begin
      errors++;
      $display("FAIL %s: outLvl=%0b expected=%0b at %0t", tag, outLvl, model, $time);
    end
  endtask

  // Drive at the falling edge, update the model at the rising edge, compare at the next falling edge
  task automatic step(string tag, bit en, bit ud, bit dn, bit cm, bit pm, int md, bit sw);
    tmrEn = en; upDownMode = ud; countDown = dn; chanMatch = cm;
    periodMatch = pm; outMode = 3'(md); swOut = sw;
    @(posedge clk);
    model = refNext(model, en, ud, dn, cm, pm, md, sw);
    @(negedge clk);
    check(tag);
  endtask

  // Force a known level with mode 000
  task automatic preset(bit lvl);
    step("R2", 1, 0, 0, 0, 0, 0, lvl);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rstN = 1'b1;
    @(negedge clk);
    check("R1");

    // R2: software bit followed every cycle, strobes ignored
    for (int i = 0; i < 6; i++) step("R2", 1, 0, 0, i % 2, i % 3 == 0, 0, (i % 3) != 1);

    // R3: disabled holds in all modes and events
    preset(1);
    for (int md = 0; md < 8; md++) step("R3", 0, md % 2, 0, 1, md > 3, md, 0);
    preset(0);
    for (int md = 0; md < 8; md++) step("R3", 0, 0, 0, 1, 1, md, 1);

    // R4 / R5: isolated events in up counting from both starting levels
    for (int md = 1; md < 8; md++) begin
      for (int lv = 0; lv < 2; lv++) begin
        preset(lv[0]);
        step("R4", 1, 0, 0, 1, 0, md, 0);
        preset(lv[0]);
        step("R5", 1, 0, 0, 0, 1, md, 0);
        preset(lv[0]);
        step("R6", 1, 0, 0, 1, 1, md, 0);
        step("R10", 1, 0, 0, 0, 0, md, !lv[0]);
      end
    end

    // R7 / R8 / R9: up/down counting, both directions
    for (int md = 1; md < 8; md++) begin
      for (int lv = 0; lv < 2; lv++) begin
        for (int dn = 0; dn < 2; dn++) begin
          preset(lv[0]);
          step((md == 3 || md == 7) ? "R8" : "R7", 1, 1, dn[0], 1, 0, md, 0);
          preset(lv[0]);
          step("R9", 1, 1, dn[0], 0, 1, md, 0);
        end
      end
    end

    // R4 / R5: edge-aligned PWM, up counting, period 8, compare 5, mode 011
    preset(0);
    for (int c = 0; c < 27; c++) begin
      int cnt = c % 9;
      step("R4", 1, 0, 0, cnt == 5, cnt == 8, 3, 0);
    end

    // R7 / R9: center-aligned, up/down, period 7, compare 4, mode 010
    preset(0);
    begin
      int cnt = 0;
      bit down = 0;
      for (int c = 0; c < 42; c++) begin
        step("R7", 1, 1, down, cnt == 4, cnt == 7, 2, 0);
        if (!down) begin
          if (cnt == 7) begin down = 1; cnt = 6; end else cnt++;
        end else begin
          if (cnt == 0) begin down = 0; cnt = 1; end else cnt--;
        end
      end
    end

    // R8: set/reset over an up/down sweep
    preset(0);
    begin
      int cnt = 0;
      bit down = 0;
      for (int c = 0; c < 28; c++) begin
        step("R8", 1, 1, down, cnt == 4, cnt == 7, 3, 0);
        if (!down) begin
          if (cnt == 7) begin down = 1; cnt = 6; end else cnt++;
        end else begin
          if (cnt == 0) begin down = 0; cnt = 1; end else cnt--;
        end
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule